// File: doc/BRIEF.md
# Strobe-Driven Program/Verify Sequencer

This block is the device-side controller for a pin-driven mode that writes and checks a 16-bit wide program memory. An external programmer drives two strobe pins and one shared 16-bit address/data bus. The bus pad itself lies outside the block, so the block sees it as `bus_in` and drives it through `bus_out` and `bus_oe`. The block decides whether to enter the mode when reset is released, takes one start address, and then moves through verify and program cycles. In a verify cycle it places the stored word on the bus. In a program cycle it captures write data and holds a memory write-enable for as long as the program strobe stays high.

The step strobe reads words and advances the address. The program strobe writes. When a program cycle ends, the timing of the step strobe relative to the falling program strobe picks the next action:
- If the step strobe rises while the program strobe is still high, the same word is read back.
- If the step strobe rises after the program strobe falls, the address advances.
- If only the program strobe pulses again, the same word is written again.

Both strobes are asynchronous. Each is synchronized and filtered against glitches before the sequencer uses it.

Top module: `pv_seq`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `bus_oe` and `mem_we` are 0 and `mem_addr` is 0x0000.
- R2: The mode is entered only if the upper byte of `bus_in` equals 0xE1 in every one of the ENTRY_HOLD (default 10) cycles that follow reset release. If that check fails, the block never drives the bus, never writes and never changes `mem_addr` until the next reset.
- R3: After entry, the first filtered rising edge of `strb_step` loads all 16 bits of `bus_in` into `mem_addr`. No later strobe edge ever loads the address again.
- R4: In a verify cycle, a `strb_step` pulse raises `bus_oe` with `bus_out` equal to the word at `mem_addr`, no later than 10 cycles after the raw rise. `bus_oe` drops no later than 8 cycles after the raw fall, and it is never high while `mem_we` is high.
- R5: The `strb_step` pulse that follows a read pulse raises `mem_addr` by one and does not drive the bus. `mem_addr` changes in no other way except the load in R3.
- R6: A `strb_prog` pulse in a verify cycle starts a program cycle, and `bus_in` is captured SAMPLE_DLY (default 3) cycles after the filtered rise. From then on, `mem_we` is high with `mem_wdata` equal to the captured value until the filtered fall. `mem_addr` and `mem_wdata` stay stable throughout.
- R7: After a program cycle, if `strb_step` stays low and `strb_prog` pulses again, the same address is programmed again.
- R8: If `strb_step` rises while `strb_prog` is still high, the fall of `strb_prog` starts a read of the same, unincremented address that lasts for as long as `strb_step` stays high.
- R9: If `strb_step` rises only after `strb_prog` has fallen, that pulse raises the address by one, and the next `strb_step` pulse reads the new address.
- R10: Incrementing from 0xFFFF gives 0x0000.
- R11: A strobe pulse that lasts a single clock cycle has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset; its release opens the entry check |
| strb_step | input | 1 | Asynchronous step strobe (address load, read, advance) |
| strb_prog | input | 1 | Asynchronous program strobe (write window) |
| bus_in | input | DATA_W | Value sampled from the shared bus pad |
| bus_out | output | DATA_W | Word driven toward the bus pad; 0 when not driving |
| bus_oe | output | 1 | Enables the bus pad driver |
| mem_addr | output | ADDR_W | Program memory address |
| mem_rdata | input | DATA_W | Word read from the memory at `mem_addr` |
| mem_wdata | output | DATA_W | Registered write data |
| mem_we | output | 1 | Memory write-enable |

## Verification
The bench goes after the edge-order decision at the end of a program cycle. A design that took the early step edge as an advance would read back the wrong word, and one that lost that edge would leave the bus undriven. Single-cycle glitches are placed where a stray pulse would shift the read/advance phase, so a weak filter shows up as a read that advances instead. Entry is tried with a wrong key and with a key held too briefly, because a loose check would answer strobes. The address is loaded at 0xFFFF to catch an increment that saturates or widens instead of wrapping.

// File: rtl/pv_pkg.sv
package pv_pkg;

    // Index of each strobe in the filtered strobe array
    localparam int IDX_PROG = 0;
    localparam int IDX_STEP = 1;
    localparam int N_STROBE = 2;

    // Filtered strobe: level plus single-cycle edge events
    typedef struct packed {
        logic lvl;
        logic rise;
        logic fall;
    } strobe_t;

    typedef enum logic [2:0] {
        ST_ENTRY,    // checking the entry key after reset release
        ST_DEAD,     // entry refused, inert until reset
        ST_LOAD,     // waiting for the address-load step edge
        ST_RD_ARM,   // verify cycle: next step pulse reads
        ST_RD_OUT,   // driving the stored word
        ST_ADV_ARM,  // next step pulse advances the address
        ST_PROG      // program strobe high, write window
    } seq_state_e;

    // Route taken when the program strobe falls
    function automatic seq_state_e prog_exit(input logic step_seen,
                                             input logic step_lvl,
                                             input logic step_rise);
        if (step_rise || (step_seen && step_lvl))
            return ST_RD_OUT;
        return ST_ADV_ARM;
    endfunction

endpackage

// File: rtl/pv_strobe_filt.sv
module pv_strobe_filt
    import pv_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    raw,
    output strobe_t st
);
    // [0],[1] synchronizer; [2] confirm stage
    logic [2:0] sh;
    logic       lvl_q;
    logic       agree;

    assign agree = (sh[2] == sh[1]);

    always_ff @(posedge clk) begin
        if (rst) begin
            sh    <= '0;
            lvl_q <= 1'b0;
        end else begin
            sh <= {sh[1:0], raw};
            if (agree)
                lvl_q <= sh[1];
        end
    end

    assign st.lvl  = lvl_q;
    assign st.rise = agree &&  sh[1] && !lvl_q;
    assign st.fall = agree && !sh[1] &&  lvl_q;

endmodule

// File: rtl/pv_addr_ctr.sv
module pv_addr_ctr #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              inc,
    input  logic [ADDR_W-1:0] load_val,
    output logic [ADDR_W-1:0] addr
);
    logic [ADDR_W-1:0] addr_q;

    always_ff @(posedge clk) begin
        if (rst)
            addr_q <= '0;
        else if (load)
            addr_q <= load_val;
        else if (inc)
            addr_q <= addr_q + ADDR_W'(1);
    end

    assign addr = addr_q;

endmodule

// File: rtl/pv_ctrl.sv
module pv_ctrl
    import pv_pkg::*;
#(
    parameter int                DATA_W     = 16,
    parameter int                KEY_W      = DATA_W / 2,
    parameter logic [KEY_W-1:0]  ENTRY_KEY  = KEY_W'('hE1),
    parameter int                ENTRY_HOLD = 10,
    parameter int                SAMPLE_DLY = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  strobe_t           step,
    input  strobe_t           prog,
    input  logic [DATA_W-1:0] bus_in,
    output logic              addr_load,
    output logic              addr_inc,
    output logic              drive_en,
    output logic              write_en,
    output logic              mode_live,
    output logic [DATA_W-1:0] wdata
);
    localparam int HOLD_W = $clog2(ENTRY_HOLD + 1);
    localparam int DLY_W  = $clog2(SAMPLE_DLY + 1);
    localparam logic [HOLD_W-1:0] HOLD_LAST = HOLD_W'(ENTRY_HOLD - 1);
    localparam logic [DLY_W-1:0]  DLY_LAST  = DLY_W'(SAMPLE_DLY - 1);

    seq_state_e        state, nxt;
    logic [HOLD_W-1:0] hold_cnt;
    logic [DLY_W-1:0]  dly_cnt;
    logic              we_on;
    logic              step_seen;
    logic [KEY_W-1:0]  key_hi;

    assign key_hi = bus_in[DATA_W-1 -: KEY_W];

    always_comb begin
        nxt       = state;
        addr_load = 1'b0;
        addr_inc  = 1'b0;
        unique case (state)
            ST_ENTRY: begin
                if (key_hi != ENTRY_KEY)
                    nxt = ST_DEAD;
                else if (hold_cnt == HOLD_LAST)
                    nxt = ST_LOAD;
            end
            ST_DEAD: nxt = ST_DEAD;
            ST_LOAD: begin
                if (step.rise) begin
                    addr_load = 1'b1;
                    nxt       = ST_RD_ARM;
                end
            end
            ST_RD_ARM: begin
                if (step.rise)
                    nxt = ST_RD_OUT;
                else if (prog.rise)
                    nxt = ST_PROG;
            end
            ST_RD_OUT: begin
                if (step.fall)
                    nxt = ST_ADV_ARM;
            end
            ST_ADV_ARM: begin
                if (step.rise) begin
                    addr_inc = 1'b1;
                    nxt      = ST_RD_ARM;
                end else if (prog.rise) begin
                    nxt = ST_PROG;
                end
            end
            ST_PROG: begin
                if (prog.fall)
                    nxt = prog_exit(step_seen, step.lvl, step.rise);
            end
            default: nxt = ST_DEAD;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_ENTRY;
            hold_cnt  <= '0;
            dly_cnt   <= '0;
            we_on     <= 1'b0;
            step_seen <= 1'b0;
            wdata     <= '0;
        end else begin
            state <= nxt;
            if (state == ST_ENTRY && hold_cnt != HOLD_LAST)
                hold_cnt <= hold_cnt + HOLD_W'(1);
            if (state == ST_PROG && nxt == ST_PROG) begin
                if (!we_on) begin
                    if (dly_cnt == DLY_LAST) begin
                        we_on <= 1'b1;
                        wdata <= bus_in;
                    end else begin
                        dly_cnt <= dly_cnt + DLY_W'(1);
                    end
                end
                if (step.rise)
                    step_seen <= 1'b1;
            end else begin
                dly_cnt   <= '0;
                we_on     <= 1'b0;
                step_seen <= 1'b0;
            end
        end
    end

    assign drive_en  = (state == ST_RD_OUT);
    assign write_en  = (state == ST_PROG) && we_on;
    assign mode_live = (state != ST_DEAD);

endmodule

// File: rtl/pv_seq.sv
module pv_seq
    import pv_pkg::*;
#(
    parameter int                ADDR_W     = 16,
    parameter int                DATA_W     = 16,
    parameter int                KEY_W      = DATA_W / 2,
    parameter logic [KEY_W-1:0]  ENTRY_KEY  = KEY_W'('hE1),
    parameter int                ENTRY_HOLD = 10,
    parameter int                SAMPLE_DLY = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              strb_step,
    input  logic              strb_prog,
    input  logic [DATA_W-1:0] bus_in,
    output logic [DATA_W-1:0] bus_out,
    output logic              bus_oe,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_we
);
    logic [N_STROBE-1:0] strb_raw;
    strobe_t             strb_st [N_STROBE];
    logic                addr_ld;
    logic                addr_adv;
    logic                drive_en;
    logic                mode_live;
    logic                step_level;

    always_comb begin
        strb_raw           = '0;
        strb_raw[IDX_STEP] = strb_step;
        strb_raw[IDX_PROG] = strb_prog;
    end

    for (genvar g = 0; g < N_STROBE; g++) begin : g_filt
        pv_strobe_filt u_filt (
            .clk (clk),
            .rst (rst),
            .raw (strb_raw[g]),
            .st  (strb_st[g])
        );
    end

    assign step_level = strb_st[IDX_STEP].lvl;

    pv_ctrl #(
        .DATA_W     (DATA_W),
        .KEY_W      (KEY_W),
        .ENTRY_KEY  (ENTRY_KEY),
        .ENTRY_HOLD (ENTRY_HOLD),
        .SAMPLE_DLY (SAMPLE_DLY)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .step      (strb_st[IDX_STEP]),
        .prog      (strb_st[IDX_PROG]),
        .bus_in    (bus_in),
        .addr_load (addr_ld),
        .addr_inc  (addr_adv),
        .drive_en  (drive_en),
        .write_en  (mem_we),
        .mode_live (mode_live),
        .wdata     (mem_wdata)
    );

    pv_addr_ctr #(
        .ADDR_W (ADDR_W)
    ) u_addr (
        .clk      (clk),
        .rst      (rst),
        .load     (addr_ld),
        .inc      (addr_adv),
        .load_val (bus_in[ADDR_W-1:0]),
        .addr     (mem_addr)
    );

    assign bus_oe  = drive_en;
    assign bus_out = drive_en ? mem_rdata : '0;

endmodule

// File: rtl/pv_seq_chk.sv
module pv_seq_chk #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_oe,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_wdata,
    input logic              addr_ld,
    input logic              mode_live,
    input logic              step_level
);
    // R4
    drive_write_excl_chk: assert property (@(posedge clk) disable iff (rst)
        bus_oe |-> !mem_we);

    // R4
    drive_needs_step_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_oe) |-> step_level);

    // R6
    write_window_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_we && $past(mem_we)) |-> ($stable(mem_addr) && $stable(mem_wdata)));

    // R5 R10
    addr_single_step_chk: assert property (@(posedge clk) disable iff (rst)
        ((mem_addr != $past(mem_addr)) && !$past(addr_ld))
            |-> (mem_addr == $past(mem_addr) + ADDR_W'(1)));

    // R2
    refused_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !mode_live |-> (!bus_oe && !mem_we && !addr_ld));

endmodule

bind pv_seq pv_seq_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_oe     (bus_oe),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .addr_ld    (addr_ld),
    .mode_live  (mode_live),
    .step_level (step_level)
);

// File: tb/sim_pv_seq.sv
module sim_pv_seq;
    localparam int AW = 16;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          strb_step = 1'b0;
    logic          strb_prog = 1'b0;
    logic [DW-1:0] bus_in = '0;
    logic [DW-1:0] bus_out;
    logic          bus_oe;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_rdata;
    logic [DW-1:0] mem_wdata;
    logic          mem_we;

    logic [15:0] store   [256];
    logic [15:0] ref_mem [256];
    int  n_chk = 0;
    int  n_bad = 0;
    bit  done  = 0;
    logic [15:0] ea;

    always #4 clk = ~clk;

    pv_seq u0 (
        .clk       (clk),
        .rst       (rst),
        .strb_step (strb_step),
        .strb_prog (strb_prog),
        .bus_in    (bus_in),
        .bus_out   (bus_out),
        .bus_oe    (bus_oe),
        .mem_addr  (mem_addr),
        .mem_rdata (mem_rdata),
        .mem_wdata (mem_wdata),
        .mem_we    (mem_we)
    );

    function automatic logic [15:0] fill(input int i);
        return 16'((i * 40503) ^ 16'hC3A5);
    endfunction

    // memory model (aliased to 256 words)
    assign mem_rdata = store[mem_addr[7:0]];
    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 256; i++) store[i] <= fill(i);
        end else if (mem_we) begin
            store[mem_addr[7:0]] <= mem_wdata;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic start(input logic [7:0] key, input int hold);
        rst = 1'b1; strb_step = 1'b0; strb_prog = 1'b0;
        bus_in = {key, 8'h00};
        cyc(4);
        for (int i = 0; i < 256; i++) ref_mem[i] = fill(i);
        rst = 1'b0;
        cyc(hold);
        bus_in = '0;
        cyc(4);
    endtask

    task automatic load_addr(input logic [15:0] a);
        bus_in = a; strb_step = 1'b1; cyc(12);
        strb_step = 1'b0; cyc(12);
        bus_in = '0;
        chk("R3 load", {16'h0, mem_addr}, {16'h0, a});
    endtask

    task automatic read_word(input logic [15:0] exp, input string req);
        strb_step = 1'b1; cyc(10);
        chk(req, {31'h0, bus_oe}, 32'h1);
        chk(req, {16'h0, bus_out}, {16'h0, exp});
        cyc(4); strb_step = 1'b0; cyc(8);
        chk(req, {31'h0, bus_oe}, 32'h0);
        cyc(4);
    endtask

    task automatic step_adv(input string req);
        strb_step = 1'b1; cyc(10);
        chk(req, {31'h0, bus_oe}, 32'h0);
        cyc(4); strb_step = 1'b0; cyc(12);
    endtask

    task automatic prog_word(input logic [15:0] d, input bit early,
                             input logic [15:0] a, input string req);
        bus_in = d; strb_prog = 1'b1; cyc(12);
        chk(req, {31'h0, mem_we}, 32'h1);
        chk(req, {16'h0, mem_wdata}, {16'h0, d});
        chk(req, {16'h0, mem_addr}, {16'h0, a});
        ref_mem[a[7:0]] = d;
        if (early) begin
            strb_step = 1'b1; cyc(6);
            strb_prog = 1'b0; cyc(10);
            chk("R8 readback", {31'h0, bus_oe}, 32'h1);
            chk("R8 readback", {16'h0, bus_out}, {16'h0, d});
            chk("R8 no write", {31'h0, mem_we}, 32'h0);
            strb_step = 1'b0; cyc(12);
            chk("R8 no advance", {16'h0, mem_addr}, {16'h0, a});
        end else begin
            cyc(4); strb_prog = 1'b0; cyc(8);
            chk(req, {31'h0, mem_we}, 32'h0);
            cyc(4);
        end
        bus_in = '0;
    endtask

    task automatic expect_quiet(input string req);
        bus_in = 16'h0033; strb_step = 1'b1; cyc(10);
        chk(req, {31'h0, bus_oe}, 32'h0);
        strb_step = 1'b0; cyc(10);
        chk(req, {16'h0, mem_addr}, 32'h0);
        strb_prog = 1'b1; cyc(12);
        chk(req, {31'h0, mem_we}, 32'h0);
        strb_prog = 1'b0; cyc(10);
        bus_in = '0;
    endtask

    initial begin
        void'($urandom(32'h5EED));
        // R1 reset state
        rst = 1'b1; cyc(4);
        chk("R1 oe", {31'h0, bus_oe}, 32'h0);
        chk("R1 we", {31'h0, mem_we}, 32'h0);
        chk("R1 addr", {16'h0, mem_addr}, 32'h0);

        // R2 wrong key
        start(8'h00, 12);
        expect_quiet("R2 wrong key");
        // R2 key held too briefly
        start(8'hE1, 3);
        expect_quiet("R2 short hold");

        // proper entry
        start(8'hE1, 12);
        load_addr(16'h0010);
        // R11 glitches in the read-armed phase must not shift the phase
        strb_step = 1'b1; cyc(1); strb_step = 1'b0; cyc(10);
        chk("R11 step glitch", {31'h0, bus_oe}, 32'h0);
        strb_prog = 1'b1; cyc(1); strb_prog = 1'b0; cyc(10);
        chk("R11 prog glitch", {31'h0, mem_we}, 32'h0);
        read_word(ref_mem[8'h10], "R4 first read");
        strb_step = 1'b1; cyc(1); strb_step = 1'b0; cyc(10);
        chk("R11 addr held", {16'h0, mem_addr}, 32'h0010);
        step_adv("R5 advance");
        chk("R5 addr", {16'h0, mem_addr}, 32'h0011);

        // R6 write, R7 rewrite, R8 early step readback
        prog_word(16'hA5A5, 1'b0, 16'h0011, "R6 write");
        prog_word(16'h3C4D, 1'b1, 16'h0011, "R7 rewrite");
        step_adv("R5 advance");
        chk("R5 addr", {16'h0, mem_addr}, 32'h0012);
        // R9 late step advances
        prog_word(16'h1234, 1'b0, 16'h0012, "R6 write");
        step_adv("R9 late step");
        chk("R9 addr", {16'h0, mem_addr}, 32'h0013);
        read_word(ref_mem[8'h13], "R9 read next");
        step_adv("R5 advance");
        ea = 16'h0014;

        // constrained random mix
        for (int k = 0; k < 24; k++) begin
            int unsigned op;
            logic [15:0] d;
            op = $urandom_range(2, 0);
            d  = 16'($urandom);
            case (op)
                0: begin
                    read_word(ref_mem[ea[7:0]], "R4 rand read");
                    step_adv("R5 rand advance");
                    ea = ea + 16'd1;
                    chk("R5 rand addr", {16'h0, mem_addr}, {16'h0, ea});
                end
                1: begin
                    prog_word(d, 1'b0, ea, "R6 rand write");
                    step_adv("R9 rand late");
                    ea = ea + 16'd1;
                    chk("R9 rand addr", {16'h0, mem_addr}, {16'h0, ea});
                    read_word(ref_mem[ea[7:0]], "R9 rand read");
                    step_adv("R5 rand advance");
                    ea = ea + 16'd1;
                end
                default: begin
                    prog_word(d, 1'b1, ea, "R8 rand early");
                    step_adv("R5 rand advance");
                    ea = ea + 16'd1;
                    chk("R5 rand addr", {16'h0, mem_addr}, {16'h0, ea});
                end
            endcase
        end

        // R10 wrap
        start(8'hE1, 12);
        load_addr(16'hFFFF);
        read_word(ref_mem[8'hFF], "R10 top read");
        step_adv("R10 advance");
        chk("R10 wrap", {16'h0, mem_addr}, 32'h0000);
        read_word(ref_mem[8'h00], "R10 bottom read");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule